// File: doc/BRIEF.md
# Selectable Line-Code Receive Decoder

This block sits in the receive path of a T1/E1 line interface, after clock recovery and the analog slicer. It accepts positive and negative rail pulses retimed to the recovered clock, and the raw slicer rails before retiming. A 2-bit mode input picks what the block drives out. It can decode with zero substitution into single-rail NRZ. It can decode plain AMI into single-rail NRZ. It can pass the retimed dual-rail NRZ pulses through. It can also pass the raw slicer pulses through untouched, in RZ form.

Further controls shape the output. One selects HDB3 (E1) or B8ZS (T1) substitution. One inverts every output. One moves output updates to the falling clock edge. One powers the receiver down. In both decoding modes the symbols pass through an eight-symbol lookahead window. This window is what lets a complete substitution code be recognised and blanked before any of its marks leave the block.

Top module: `rx_line_decoder`

## Requirements
- R1: After reset, with all controls at 0, data_out, rail_p_out and rail_n_out are 0.
- R2: With mode 2'b01 (AMI), a mark on either rail, or on both rails at once, gives a 1 and a space gives a 0. No substitution is removed. A symbol sampled at rising edge k appears on data_out after rising edge k+8.
- R3: With mode 2'b00 and e1_sel=1 (HDB3), a mark whose polarity matches the previous mark is a violation. The positive rail sets the polarity when both rails are active. A violation preceded by two spaces (000V or B00V) is output as four zeros. Other marks come out as 1, with the R2 latency.
- R4: With mode 2'b00 and e1_sel=0 (B8ZS), the eight-symbol code 000VB0VB is output as eight zeros. An HDB3-style 000V is left unchanged.
- R5: In modes 2'b00 and 2'b01, rail_p_out and rail_n_out stay at the inactive level.
- R6: In mode 2'b10, the rails sampled at a rising edge appear on rail_p_out and rail_n_out after that edge, and data_out stays inactive.
- R7: In mode 2'b11, slice_p_in and slice_n_in drive rail_p_out and rail_n_out with no register in between, whatever the value of edge_fall.
- R8: inv_en=1 inverts all three outputs; the inactive level of every output equals inv_en.
- R9: With edge_fall=1 in modes 2'b00 to 2'b10, outputs change at the falling edge half a cycle after the rising edge that would otherwise update them.
- R10: While pwr_down=1 all outputs sit at the inactive level and the decode history is cleared, so no mark received while powered down reaches data_out afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail_p_in | input | 1 | Retimed positive-pulse rail |
| rail_n_in | input | 1 | Retimed negative-pulse rail |
| slice_p_in | input | 1 | Raw slicer positive rail (RZ) |
| slice_n_in | input | 1 | Raw slicer negative rail (RZ) |
| mode | input | 2 | 00 substitution decode, 01 AMI, 10 dual-rail, 11 slicer |
| e1_sel | input | 1 | 1 selects HDB3, 0 selects B8ZS |
| inv_en | input | 1 | Output polarity inversion |
| edge_fall | input | 1 | 1 updates outputs on the falling clock edge |
| pwr_down | input | 1 | Receiver power down |
| data_out | output | 1 | Single-rail NRZ decoded data |
| rail_p_out | output | 1 | Positive rail output (dual-rail or slicer) |
| rail_n_out | output | 1 | Negative rail output (dual-rail or slicer) |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover the inactive output level while powered down, the quiet outputs of each mode family, the one-edge retiming of dual-rail data, and the eight-edge AMI path compared against the incoming marks. Other behaviour depends on a whole symbol history, so only the bench's scenarios can show it. That covers HDB3 and B8ZS blanking, the decision to leave an E1 code untouched in T1 mode, the half-cycle shift from edge selection, and the history being cleared after power down.

// File: rtl/rx_line_decoder.sv
module rx_line_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rail_p_in,
  input  logic       rail_n_in,
  input  logic       slice_p_in,
  input  logic       slice_n_in,
  input  logic [1:0] mode,
  input  logic       e1_sel,
  input  logic       inv_en,
  input  logic       edge_fall,
  input  logic       pwr_down,
  output logic       data_out,
  output logic       rail_p_out,
  output logic       rail_n_out
);
  localparam logic [1:0] M_SUB = 2'b00, M_DUAL = 2'b10, M_SLICE = 2'b11;

  logic [7:0] mk, mk_nxt;
  logic [3:0] vi;
  logic       last_p, seen;
  logic       q_d, q_p, q_n, f_d, f_p, f_n;
  logic       mark, viol, sub_en, hdb_hit, b8_hit;
  logic       sel_d, sel_p, sel_n;

  assign mark    = rail_p_in | rail_n_in;
  assign viol    = mark & seen & (rail_p_in == last_p);
  assign sub_en  = (mode == M_SUB);
  assign hdb_hit = sub_en & e1_sel & viol & (mk[1:0] == 2'b00);
  assign b8_hit  = sub_en & ~e1_sel & mark & ~viol
                 & mk[0] & vi[0] & ~mk[1] & mk[2] & ~vi[2] & mk[3] & vi[3]
                 & (mk[6:4] == 3'b000);

  always_comb begin
    mk_nxt = {mk[6:0], mark};
    if (hdb_hit) mk_nxt[3:0] = 4'b0000;
    if (b8_hit)  mk_nxt = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk <= '0; vi <= '0; last_p <= 1'b0; seen <= 1'b0;
      q_d <= 1'b0; q_p <= 1'b0; q_n <= 1'b0;
    end else if (pwr_down) begin
      mk <= '0; vi <= '0; last_p <= 1'b0; seen <= 1'b0;
      q_d <= 1'b0; q_p <= 1'b0; q_n <= 1'b0;
    end else begin
      mk <= mk_nxt;
      vi <= {vi[2:0], viol};
      if (mark) begin
        last_p <= rail_p_in;
        seen   <= 1'b1;
      end
      q_d <= ~mode[1] & mk[7];
      q_p <= (mode == M_DUAL) & rail_p_in;
      q_n <= (mode == M_DUAL) & rail_n_in;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_d <= 1'b0; f_p <= 1'b0; f_n <= 1'b0;
    end else if (pwr_down) begin
      f_d <= 1'b0; f_p <= 1'b0; f_n <= 1'b0;
    end else begin
      f_d <= q_d; f_p <= q_p; f_n <= q_n;
    end
  end

  assign sel_d = edge_fall ? f_d : q_d;
  assign sel_p = (mode == M_SLICE) ? slice_p_in : (edge_fall ? f_p : q_p);
  assign sel_n = (mode == M_SLICE) ? slice_n_in : (edge_fall ? f_n : q_n);

  assign data_out   = pwr_down ? inv_en : (sel_d ^ inv_en);
  assign rail_p_out = pwr_down ? inv_en : (sel_p ^ inv_en);
  assign rail_n_out = pwr_down ? inv_en : (sel_n ^ inv_en);
endmodule

// File: rtl/rx_line_decoder_chk.sv
module rx_line_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rail_p_in,
  input logic       rail_n_in,
  input logic       slice_p_in,
  input logic       slice_n_in,
  input logic [1:0] mode,
  input logic       e1_sel,
  input logic       inv_en,
  input logic       edge_fall,
  input logic       pwr_down,
  input logic       data_out,
  input logic       rail_p_out,
  input logic       rail_n_out
);
  logic       up;
  logic [3:0] ami_run;
  logic       ami_ok;

  assign ami_ok = (mode == 2'b01) & ~pwr_down & ~edge_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up      <= 1'b0;
      ami_run <= '0;
    end else begin
      up <= 1'b1;
      if (!ami_ok)            ami_run <= '0;
      else if (ami_run != 4'd15) ami_run <= ami_run + 4'd1;
    end
  end

  p_pd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (data_out == inv_en && rail_p_out == inv_en && rail_n_out == inv_en));

  p_single_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !pwr_down) |-> (rail_p_out == inv_en && rail_n_out == inv_en));

  p_dual_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !pwr_down && (mode == 2'b11 || !edge_fall)) |-> data_out == inv_en);

  p_dual_retime_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up && mode == 2'b10 && !pwr_down && !edge_fall &&
     $past(mode == 2'b10 && !pwr_down && !edge_fall))
    |-> (rail_p_out == ($past(rail_p_in) ^ inv_en) &&
         rail_n_out == ($past(rail_n_in) ^ inv_en)));

  p_ami_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ami_ok && ami_run >= 4'd9)
    |-> data_out == ($past(rail_p_in | rail_n_in, 9) ^ inv_en));
endmodule

bind rx_line_decoder rx_line_decoder_chk i_chk (.*);

// File: tb/test_rx_line_decoder.sv
module test_rx_line_decoder;
  logic clk = 1'b0;
  logic rst_n, rp, rn, sp, sn, e1, inv, fall, pd;
  logic [1:0] mode;
  logic dout, pout, nout;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_line_decoder i_rx_line_decoder (
    .clk(clk), .rst_n(rst_n), .rail_p_in(rp), .rail_n_in(rn),
    .slice_p_in(sp), .slice_n_in(sn), .mode(mode), .e1_sel(e1),
    .inv_en(inv), .edge_fall(fall), .pwr_down(pd),
    .data_out(dout), .rail_p_out(pout), .rail_n_out(nout));

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rp = 0; rn = 0; sp = 0; sn = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic run_stream(input logic [15:0] p, input logic [15:0] n,
                            input logic [15:0] exp, input int len, input string req);
    for (int i = 0; i < len + 8; i++) begin
      rp = (i < len) ? p[i] : 1'b0;
      rn = (i < len) ? n[i] : 1'b0;
      @(posedge clk); #2;
      if (i >= 8) chk(dout, exp[i-8] ^ inv, req);
    end
  endtask

  task automatic t_reset();
    mode = 2'b00; e1 = 0; inv = 0; fall = 0; pd = 0;
    do_reset();
    chk(dout, 1'b0, "R1 data");
    chk(pout, 1'b0, "R1 rail_p");
    chk(nout, 1'b0, "R1 rail_n");
  endtask

  task automatic t_ami();
    mode = 2'b01; do_reset();
    run_stream(16'b111001, 16'b100100, 16'b111101, 6, "R2 ami");
    chk(pout, 1'b0, "R5 rail_p quiet");
    chk(nout, 1'b0, "R5 rail_n quiet");
  endtask

  task automatic t_hdb3();
    mode = 2'b00; e1 = 1;
    do_reset(); run_stream(16'b10001, 16'b00000, 16'b00001, 5, "R3 000V");
    do_reset(); run_stream(16'b00001, 16'b10010, 16'b00001, 5, "R3 B00V");
    do_reset(); run_stream(16'b1001, 16'b0010, 16'b1011, 4, "R3 plain marks");
  endtask

  task automatic t_b8zs();
    mode = 2'b00; e1 = 0;
    do_reset(); run_stream(16'b100010001, 16'b010100000, 16'b000000001, 9, "R4 b8zs");
    do_reset(); run_stream(16'b10001, 16'b00000, 16'b10001, 5, "R4 000V kept");
    chk(pout, 1'b0, "R5 rail_p in sub mode");
  endtask

  task automatic t_dual();
    mode = 2'b10; do_reset();
    rp = 1; rn = 0; @(posedge clk); #2;
    chk(pout, 1'b1, "R6 p"); chk(nout, 1'b0, "R6 n"); chk(dout, 1'b0, "R6 data quiet");
    rp = 0; rn = 1; @(posedge clk); #2;
    chk(pout, 1'b0, "R6 p"); chk(nout, 1'b1, "R6 n");
  endtask

  task automatic t_slicer();
    mode = 2'b11; fall = 1; do_reset();
    sp = 1; sn = 0; #1;
    chk(pout, 1'b1, "R7 p"); chk(nout, 1'b0, "R7 n");
    sp = 0; sn = 1; #1;
    chk(pout, 1'b0, "R7 p"); chk(nout, 1'b1, "R7 n");
    fall = 0;
  endtask

  task automatic t_invert();
    mode = 2'b10; inv = 1; do_reset();
    rp = 1; rn = 0; @(posedge clk); #2;
    chk(pout, 1'b0, "R8 p inverted"); chk(nout, 1'b1, "R8 n inverted");
    chk(dout, 1'b1, "R8 data inactive high");
    mode = 2'b01; do_reset();
    run_stream(16'b0101, 16'b0000, 16'b0101, 4, "R8 ami inverted");
    inv = 0;
  endtask

  task automatic t_edge();
    mode = 2'b10; fall = 1; do_reset();
    rp = 0; rn = 0; repeat (2) @(posedge clk); #2;
    rp = 1; @(posedge clk); #2;
    chk(pout, 1'b0, "R9 not yet at rising edge");
    @(negedge clk); #2;
    chk(pout, 1'b1, "R9 updated at falling edge");
    fall = 0;
  endtask

  task automatic t_pd();
    mode = 2'b01; inv = 1; do_reset();
    pd = 1; rp = 1; rn = 1;
    repeat (4) begin
      @(posedge clk); #2;
      chk(dout, 1'b1, "R10 data idle"); chk(pout, 1'b1, "R10 p idle"); chk(nout, 1'b1, "R10 n idle");
    end
    pd = 0; inv = 0; rp = 0; rn = 0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk); #2;
      chk(dout, 1'b0, "R10 history cleared");
    end
  endtask

  initial begin
    t_reset(); t_ami(); t_hdb3(); t_b8zs(); t_dual();
    t_slicer(); t_invert(); t_edge(); t_pd();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule